// File: doc/BRIEF.md
# DMA channel control and interrupt unit

This unit holds the per-channel configuration of a multi-channel peripheral DMA controller and turns it into transfer requests for a separate datapath engine. Each channel has one control word, written and read through a simple register port addressed by channel number. From it the unit derives the beat width, the transfer mode and the effective direction. It also gates one of sixteen fixed peripheral ready lines into that channel's transfer request.

The datapath engine pulses a per-channel completion input when a transfer finishes. The unit latches this into a sticky completion flag, which software clears with a write-only strobe. A second write-only strobe returns a channel to its reset state. A single interrupt output is raised while any channel has both its completion flag and its interrupt enable set.

Top module: `dma_cc_top`

Control word layout (write): bit 0 interrupt enable, bit 1 pause, bits 3:2 beat size, bit 4 peripheral mode, bit 5 direction, bits 9:6 source select, bit 12 clear-completion strobe, bit 13 channel-reset strobe. On read, bits 9:0 return the stored fields, bit 16 returns the completion flag, and all other bits read 0.

## Requirements
- R1: After rst_ni is released, every channel's fields and completion flag are 0. Read data is 0, irq_o is 0 and every xfer_req_o bit is 1, because every channel is then unpaused memory-to-memory.
- R2: A write to channel `reg_addr_i` stores bits 9:0. Reads of that channel return them in the same positions, with the completion flag at bit 16. Bits 12 and 13 always read back as 0.
- R3: beat_size_o of a channel is 0 for an 8-bit beat, 1 for 16-bit and 2 for 32-bit, following size field values 00, 01 and 10. The reserved size 11 gives 0 (8-bit), so beat_size_o is never 3.
- R4: In peripheral mode (bit 4 = 1), an unpaused channel's xfer_req_o equals periph_rdy_i[src], where src is the 4-bit select. No other ready line affects it.
- R5: In memory-to-memory mode (bit 4 = 0), an unpaused channel's xfer_req_o is 1 and the ready lines have no effect. periph_mode_o reflects bit 4.
- R6: While the pause bit is 1, the channel's xfer_req_o is 0 whatever the ready lines and the mode.
- R7: to_periph_o is 0 in memory-to-memory mode. In peripheral mode it follows the select code: codes 0 to 7 give the code's LSB; 10 and 15 give 1; 11 and 14 give 0; codes 8, 9, 12 and 13 give the direction bit.
- R8: A done_i pulse on a channel sets its completion flag at the next clock edge, where it stays until cleared or reset.
- R9: A write with bit 12 set clears that channel's completion flag at the next edge. If done_i for that channel is high in the same cycle, the flag stays set.
- R10: irq_o is high exactly while some channel has both its completion flag and its interrupt enable set. Clearing one channel leaves irq_o high while another enabled channel still holds its flag.
- R11: A write with bit 13 set returns that channel's fields and completion flag to 0 at the next edge. This happens whatever the other write bits and done_i are, and other channels are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | CH_AW | Channel number for write and read |
| reg_wdata_i | input | 32 | Write data (control word) |
| reg_rdata_o | output | 32 | Read data of the addressed channel |
| periph_rdy_i | input | 16 | Peripheral ready lines, indexed by select code |
| done_i | input | NUM_CH | Per-channel completion pulses from the datapath |
| xfer_req_o | output | NUM_CH | Per-channel transfer request to the datapath |
| beat_size_o | output | NUM_CH x 2 | Per-channel beat width code |
| to_periph_o | output | NUM_CH | Per-channel effective direction, 1 = memory to peripheral |
| periph_mode_o | output | NUM_CH | Per-channel peripheral-mode flag |
| irq_o | output | 1 | Shared completion interrupt |

## Verification
The request gating is tried three ways. First, all sixteen select codes are swept with a one-hot ready vector and then its complement; this separates a correct line selection from a neighbouring or inverted index. Second, memory mode is run with ready lines toggling, which shows the lines are ignored. Third, pause is applied in both modes. Completion handling is driven with overlapping flags on two enabled channels, a clear that coincides with a new pulse, and a channel reset carrying other bits set. These cases separate per-channel clearing from a global clear, and show that the clear loses to a new event. A long random run with a cycle-by-cycle reference model compares every output on every clock.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;

  localparam int NUM_SRC   = 16;
  localparam int CFG_W     = 10;
  localparam int BIT_CLR   = 12;
  localparam int BIT_RST   = 13;
  localparam int BIT_DONE  = 16;
  localparam int REG_W     = 32;

  typedef enum logic [1:0] {
    BEAT_8  = 2'b00,
    BEAT_16 = 2'b01,
    BEAT_32 = 2'b10
  } beat_e;

  // Packed order gives int_en at bit 0 ... src at bits 9:6
  typedef struct packed {
    logic [3:0] src;
    logic       dir;
    logic       pmode;
    logic [1:0] size;
    logic       pause;
    logic       int_en;
  } chan_cfg_t;

  function automatic beat_e beat_of(logic [1:0] size);
    case (size)
      2'b01:   return BEAT_16;
      2'b10:   return BEAT_32;
      default: return BEAT_8;
    endcase
  endfunction

  // Direction implied by the source select; fabric codes defer to dir bit
  function automatic logic to_periph_of(chan_cfg_t c);
    if (!c.pmode) return 1'b0;
    case (c.src)
      4'd8, 4'd9, 4'd12, 4'd13: return c.dir;
      4'd10, 4'd15:             return 1'b1;
      4'd11, 4'd14:             return 1'b0;
      default:                  return c.src[0];
    endcase
  endfunction

endpackage

// File: rtl/dma_cc_chan.sv
module dma_cc_chan
  import dma_cc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  chan_cfg_t wr_cfg_i,
  input  logic      clr_i,
  input  logic      rst_cmd_i,
  input  logic      done_i,
  output chan_cfg_t cfg_o,
  output logic      done_o
);

  chan_cfg_t cfg_q;
  logic      done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else if (wr_i && rst_cmd_i) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else if (wr_i) begin
      cfg_q  <= wr_cfg_i;
      done_q <= done_i | (done_q & ~clr_i);
    end else begin
      done_q <= done_i | done_q;
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = done_q;

  AST_DONE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !(wr_i && rst_cmd_i) |=> done_q); // R8

  AST_CLR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && clr_i && !rst_cmd_i && !done_i |=> !done_q); // R9

  AST_CHAN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && rst_cmd_i |=> (cfg_q == '0) && !done_q); // R11

endmodule

// File: rtl/dma_cc_route.sv
module dma_cc_route
  import dma_cc_pkg::*;
(
  input  chan_cfg_t          cfg_i,
  input  logic [NUM_SRC-1:0] rdy_i,
  output logic               req_o,
  output logic [1:0]         beat_o,
  output logic               to_periph_o,
  output logic               pmode_o
);

  logic launch;

  always_comb begin
    launch = cfg_i.pmode ? rdy_i[cfg_i.src] : 1'b1;
    req_o  = launch & ~cfg_i.pause;
  end

  assign beat_o      = beat_of(cfg_i.size);
  assign to_periph_o = to_periph_of(cfg_i);
  assign pmode_o     = cfg_i.pmode;

endmodule

// File: rtl/dma_cc_top.sv
module dma_cc_top
  import dma_cc_pkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_we_i,
  input  logic [CH_AW-1:0]       reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  input  logic [15:0]            periph_rdy_i,
  input  logic [NUM_CH-1:0]      done_i,
  output logic [NUM_CH-1:0]      xfer_req_o,
  output logic [NUM_CH-1:0][1:0] beat_size_o,
  output logic [NUM_CH-1:0]      to_periph_o,
  output logic [NUM_CH-1:0]      periph_mode_o,
  output logic                   irq_o
);

  chan_cfg_t [NUM_CH-1:0] cfg;
  logic      [NUM_CH-1:0] done_flag;
  logic      [NUM_CH-1:0] wr_hit;
  chan_cfg_t              wr_cfg;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31:BIT_RST+1], reg_wdata_i[BIT_CLR-1:CFG_W]};

  assign wr_cfg = chan_cfg_t'(reg_wdata_i[CFG_W-1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_hit[c] = reg_we_i && (int'(reg_addr_i) == c);

    dma_cc_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_hit[c]),
      .wr_cfg_i  (wr_cfg),
      .clr_i     (reg_wdata_i[BIT_CLR]),
      .rst_cmd_i (reg_wdata_i[BIT_RST]),
      .done_i    (done_i[c]),
      .cfg_o     (cfg[c]),
      .done_o    (done_flag[c])
    );

    dma_cc_route u_route (
      .cfg_i       (cfg[c]),
      .rdy_i       (periph_rdy_i),
      .req_o       (xfer_req_o[c]),
      .beat_o      (beat_size_o[c]),
      .to_periph_o (to_periph_o[c]),
      .pmode_o     (periph_mode_o[c])
    );

    AST_PAUSE_NOREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg[c].pause |-> !xfer_req_o[c]); // R6

    AST_BEAT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      beat_size_o[c] != 2'b11); // R3
  end

  always_comb begin
    reg_rdata_o = '0;
    if (int'(reg_addr_i) < NUM_CH) begin
      reg_rdata_o[CFG_W-1:0] = cfg[reg_addr_i];
      reg_rdata_o[BIT_DONE]  = done_flag[reg_addr_i];
    end
  end

  always_comb begin
    irq_o = 1'b0;
    for (int c = 0; c < NUM_CH; c++) irq_o |= done_flag[c] & cfg[c].int_en;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !reg_we_i |=> irq_o); // R10

  AST_STROBES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[BIT_CLR] == 1'b0 && reg_rdata_o[BIT_RST] == 1'b0); // R2

endmodule

// File: tb/dma_cc_top_tb_top.sv
module dma_cc_top_tb_top;

  localparam int NCH = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             we = 1'b0;
  logic [1:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [15:0]      rdy = '0;
  logic [NCH-1:0]   done = '0;
  logic [NCH-1:0]   req;
  logic [NCH-1:0][1:0] beat;
  logic [NCH-1:0]   tp;
  logic [NCH-1:0]   pm;
  logic             irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference state: stored control bits 9:0 and completion flag
  int m_cfg [NCH];
  int m_dn  [NCH];

  always #10 clk = ~clk;

  dma_cc_top #(.NUM_CH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .periph_rdy_i(rdy),
    .done_i(done), .xfer_req_o(req), .beat_size_o(beat),
    .to_periph_o(tp), .periph_mode_o(pm), .irq_o(irq)
  );

  function automatic int fld(int v, int lsb, int w);
    return (v >> lsb) & ((1 << w) - 1);
  endfunction

  function automatic int e_req(int c);
    int v = m_cfg[c];
    if (fld(v, 1, 1) == 1) return 0;
    if (fld(v, 4, 1) == 0) return 1;
    return int'(rdy[fld(v, 6, 4)]);
  endfunction

  function automatic int e_beat(int c);
    int s = fld(m_cfg[c], 2, 2);
    return (s == 3) ? 0 : s;
  endfunction

  function automatic int e_tp(int c);
    int v = m_cfg[c];
    int s = fld(v, 6, 4);
    if (fld(v, 4, 1) == 0) return 0;
    if (s < 8) return s % 2;
    if (s == 10 || s == 15) return 1;
    if (s == 11 || s == 14) return 0;
    return fld(v, 5, 1);
  endfunction

  function automatic int e_irq();
    int r = 0;
    foreach (m_cfg[c]) if (m_dn[c] == 1 && fld(m_cfg[c], 0, 1) == 1) r = 1;
    return r;
  endfunction

  task automatic chk(string req_tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R8 rdata", int'(rdata), m_cfg[addr] | (m_dn[addr] << 16));
    chk("R10 irq", int'(irq), e_irq());
    for (int c = 0; c < NCH; c++) begin
      chk("R4 R5 R6 req", int'(req[c]), e_req(c));
      chk("R3 beat", int'(beat[c]), e_beat(c));
      chk("R7 to_periph", int'(tp[c]), e_tp(c));
      chk("R5 pmode", int'(pm[c]), fld(m_cfg[c], 4, 1));
    end
  endtask

  task automatic model_edge();
    for (int c = 0; c < NCH; c++) begin
      if (we && int'(addr) == c && wdata[13]) begin
        m_cfg[c] = 0; m_dn[c] = 0;
      end else if (we && int'(addr) == c) begin
        m_cfg[c] = int'(wdata[9:0]);
        if (done[c]) m_dn[c] = 1; else if (wdata[12]) m_dn[c] = 0;
      end else if (done[c]) m_dn[c] = 1;
    end
  endtask

  // drive at negedge, compare, then let the edge happen
  task automatic cyc(bit w, int a, int d, int dn, int r);
    @(negedge clk);
    we = w; addr = a[1:0]; wdata = d; done = dn[NCH-1:0]; rdy = r[15:0];
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(int a);
    cyc(0, a, 0, 0, int'(rdy));
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    foreach (m_cfg[c]) begin m_cfg[c] = 0; m_dn[c] = 0; end
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 rdata", int'(rdata), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 req", int'(req), 4'hF);

    // R2 readback, strobes read 0 (bit 12 alone must not reset)
    cyc(1, 1, 32'h0000_13FF & ~32'h2000 | 32'h1000, 0, 0);
    idle(1);
    chk("R2 readback", int'(rdata), 32'h3FF);

    // R3 sizes including reserved 11
    for (int s = 0; s < 4; s++) begin
      cyc(1, 2, s << 2, 0, 0);
      idle(2);
      chk("R3 size", int'(beat[2]), (s == 3) ? 0 : s);
    end

    // R4 R7 select sweep with one-hot ready and its complement
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 2; d++) begin
        cyc(1, 0, (s << 6) | (d << 5) | 32'h10, 0, 0);
        cyc(0, 0, 0, 0, 1 << s);
        chk("R4 sel hot", int'(req[0]), 1);
        cyc(0, 0, 0, 0, ~(1 << s) & 16'hFFFF);
        chk("R4 sel cold", int'(req[0]), 0);
        chk("R7 dir", int'(tp[0]), e_tp(0));
      end
    end

    // R5 memory mode ignores ready; R6 pause in both modes
    cyc(1, 3, 32'h3C0, 0, 0);
    cyc(0, 3, 0, 0, 16'h0000);
    chk("R5 mm no ready", int'(req[3]), 1);
    cyc(1, 3, 32'h3C2, 0, 16'hFFFF);
    idle(3);
    chk("R6 paused mm", int'(req[3]), 0);
    cyc(1, 3, 32'h3D2, 0, 16'hFFFF);
    idle(3);
    chk("R6 paused pm", int'(req[3]), 0);

    // R8 R10: two enabled channels complete
    cyc(1, 0, 1, 0, 0);
    cyc(1, 1, 1, 0, 0);
    cyc(0, 0, 0, 4'b0011, 0);
    idle(0);
    chk("R8 flag", int'(rdata[16]), 1);
    chk("R10 irq on", int'(irq), 1);
    // R9 clear ch0, ch1 still holds
    cyc(1, 0, 32'h1001, 0, 0);
    idle(0);
    chk("R9 cleared", int'(rdata[16]), 0);
    chk("R10 irq held", int'(irq), 1);
    // R9 clear together with new pulse keeps flag
    cyc(1, 1, 32'h1001, 4'b0010, 0);
    idle(1);
    chk("R9 simultaneous", int'(rdata[16]), 1);
    cyc(1, 1, 32'h1001, 0, 0);
    idle(1);
    chk("R10 irq off", int'(irq), 0);
    // R11 channel reset with other bits set and a done pulse
    cyc(1, 2, 32'h3FF, 4'b0100, 0);
    cyc(1, 2, 32'h23FF, 4'b0100, 0);
    idle(2);
    chk("R11 reset rdata", int'(rdata), 0);
    chk("R11 others kept", int'(beat[3]), e_beat(3));

    // random run against the model
    for (int i = 0; i < 3000; i++) begin
      int w = ($urandom % 3 == 0);
      int d = $urandom & 32'h33FF;
      cyc(w[0], $urandom % 4, d, (($urandom % 4) == 0) ? ($urandom & 4'hF) : 0,
          $urandom & 16'hFFFF);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule